// File: doc/BRIEF.md
# Dual-Path Variable-Length Instruction Decoder

This block turns a byte stream of variable-length instructions into decoded operation records. It owns the fetch address: each cycle it presents `fetch_addr`, and the fetch source returns a window of bytes that starts at that address. The address space wraps, so a straight-line program loops back to its start and its instructions are seen again.

Each instruction start address has a one-bit marker in a tag store. An unmarked instruction is decoded on a slow, exact path that spends three cycles on it, emits one record and then sets the marker. When the instruction at the current address is marked, a fast path emits it in one cycle and also emits the following instruction in the same cycle if that one is marked too. Two identical slot decoders do the work. A clear input drops every marker, which sends all code back through the slow path. A redirect input moves the fetch address elsewhere. A downstream ready signal stalls the registered output.

The toy encoding: the first byte of an instruction is its opcode. Opcode bits [1:0] hold the length minus one, so an instruction is 1 to 4 bytes long. Opcode bits [3:2] hold the kind: 0 register op, 1 load-op, 2 load-op-store, 3 store. Every kind produces exactly one record.

Top module: `dvd_decoder`

## Requirements
- R1: While `rst_n` is low and right after reset, `out_valid` is 0 and `fetch_addr` is 0. All markers are clear after reset.
- R2: A record is {address[16:11], length[10:8], opcode[7:0]}, using the default 6-bit address. The length equals opcode[1:0]+1. Records come out in program order, with slot 0 before slot 1.
- R3: An unmarked instruction is emitted alone (`out_valid`=01) three cycles after the decoder reaches it. Back-to-back unmarked instructions produce valid outputs exactly three cycles apart.
- R4: After an instruction has been emitted on the slow path, its marker is set, and the next time the decoder reaches that address it takes the fast path.
- R5: When both the current instruction and the one that follows it are marked, both are emitted in one cycle (`out_valid`=11). Slot 1's address is slot 0's address plus slot 0's length.
- R6: When the current instruction is marked and the next is not, only slot 0 is emitted (`out_valid`=01) that cycle. The next instruction then goes through the slow path.
- R7: Load-op (kind 1) and load-op-store (kind 2) instructions each produce exactly one record, like any other kind.
- R8: While `out_valid` is nonzero and `out_ready` is low, the outputs and `fetch_addr` hold their values. No record is lost or repeated when the stall ends.
- R9: A one-cycle `tag_clear` drops all markers. The next instruction the decoder reaches goes through the slow path.
- R10: Addresses wrap modulo 2^ADDR_W, both for the fetch address and for slot 1's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tag_clear | input | 1 | Drop all markers |
| redir_valid | input | 1 | Load a new fetch address |
| redir_addr | input | ADDR_W | New fetch address |
| fetch_addr | output | ADDR_W | Address of the first byte of the window requested |
| fetch_bytes | input | 8*WIN_BYTES | Window; byte i is at fetch_addr+i |
| out_valid | output | 2 | Valid bits of slot 1 and slot 0 |
| out_op0 | output | ADDR_W+11 | Slot 0 record |
| out_op1 | output | ADDR_W+11 | Slot 1 record |
| out_ready | input | 1 | Downstream can accept the outputs |

## Verification
The hardest case to reach from the ports is a marked instruction followed by an unmarked one. A straight loop marks instructions in order, so by the time it revisits code, every instruction in its path is already marked. The bench creates the case by resetting, letting three instructions pass through the slow path, and then redirecting back to the third. The fast path must then emit that instruction alone and hand the fourth to the slow path. The pass that pairs the last instruction of the loop with the first checks address wrap inside a fast pair.

// File: rtl/dvd_pkg.sv
package dvd_pkg;
  localparam int BYTE_W  = 8;
  localparam int LEN_W   = 3;
  localparam int MAX_LEN = 4;

  // length in bytes from the opcode byte (1..MAX_LEN)
  function automatic logic [LEN_W-1:0] op_len(input logic [BYTE_W-1:0] opc);
    return LEN_W'(opc[1:0]) + LEN_W'(1);
  endfunction
endpackage

// File: rtl/dvd_slot_dec.sv
module dvd_slot_dec
  import dvd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int WIN_BYTES = 8,
  parameter int OFS_W     = 4
) (
  input  logic [ADDR_W-1:0]           pc,
  input  logic [OFS_W-1:0]            ofs,
  input  logic [BYTE_W*WIN_BYTES-1:0] win,
  output logic [ADDR_W-1:0]           addr,
  output logic [BYTE_W-1:0]           opc,
  output logic [LEN_W-1:0]            len,
  output logic [OFS_W-1:0]            end_ofs
);
  logic [OFS_W+2:0] bit_base;

  assign bit_base = {ofs, 3'b000};
  assign opc      = win[bit_base +: BYTE_W];
  assign len      = op_len(opc);
  assign addr     = pc + ADDR_W'(ofs);
  assign end_ofs  = ofs + OFS_W'(len);
endmodule

// File: rtl/dvd_tag_store.sv
module dvd_tag_store #(
  parameter int ADDR_W = 6,
  parameter int RD     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       set_en,
  input  logic [ADDR_W-1:0]          set_idx,
  input  logic [RD-1:0][ADDR_W-1:0]  rd_idx,
  output logic [RD-1:0]              rd_tag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] tags_q, tags_d;
  logic             upd_en;

  assign upd_en = clr | set_en;

  always_comb begin
    tags_d = tags_q;
    if (clr)         tags_d = '0;
    else if (set_en) tags_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tags_q <= '0;
    else if (upd_en) tags_q <= tags_d;
  end

  for (genvar r = 0; r < RD; r++) begin : g_rd
    assign rd_tag[r] = tags_q[rd_idx[r]];
  end

  p_tag_learn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr) |=> tags_q[$past(set_idx)]);

  p_tag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tags_q == '0));
endmodule

// File: rtl/dvd_decoder.sv
module dvd_decoder
  import dvd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int WIN_BYTES = 8,
  parameter int SLOW_CYC  = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tag_clear,
  input  logic                                redir_valid,
  input  logic [ADDR_W-1:0]                   redir_addr,
  output logic [ADDR_W-1:0]                   fetch_addr,
  input  logic [8*WIN_BYTES-1:0]              fetch_bytes,
  output logic [1:0]                          out_valid,
  output logic [ADDR_W+LEN_W+BYTE_W-1:0]      out_op0,
  output logic [ADDR_W+LEN_W+BYTE_W-1:0]      out_op1,
  input  logic                                out_ready
);
  localparam int SLOTS = 2;
  localparam int OFS_W = $clog2(WIN_BYTES) + 1;
  localparam int CNT_W = $clog2(SLOW_CYC);
  localparam int OP_W  = ADDR_W + LEN_W + BYTE_W;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOW_CYC - 1);

  // slot decoders
  logic [OFS_W-1:0]  slot_ofs  [SLOTS];
  logic [OFS_W-1:0]  slot_end  [SLOTS];
  logic [ADDR_W-1:0] slot_addr [SLOTS];
  logic [BYTE_W-1:0] slot_opc  [SLOTS];
  logic [LEN_W-1:0]  slot_len  [SLOTS];
  logic [SLOTS-1:0]  slot_tag;
  logic [SLOTS-1:0][ADDR_W-1:0] tag_idx;

  // engine state
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              eng_en;

  // output stage
  logic [1:0]        val_q, val_d;
  logic [OP_W-1:0]   op0_q, op1_q;
  logic              can_load;

  logic fast_go, slow_go, slow_start, emit0, emit1;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g == 0) begin : g_first
      assign slot_ofs[g] = '0;
    end else begin : g_next
      assign slot_ofs[g] = slot_end[g-1];
    end
    dvd_slot_dec #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .OFS_W(OFS_W)) u_dec (
      .pc     (pc_q),
      .ofs    (slot_ofs[g]),
      .win    (fetch_bytes),
      .addr   (slot_addr[g]),
      .opc    (slot_opc[g]),
      .len    (slot_len[g]),
      .end_ofs(slot_end[g])
    );
    assign tag_idx[g] = slot_addr[g];
  end

  dvd_tag_store #(.ADDR_W(ADDR_W), .RD(SLOTS)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tag_clear),
    .set_en (slow_go),
    .set_idx(pc_q),
    .rd_idx (tag_idx),
    .rd_tag (slot_tag)
  );

  // path selection
  assign can_load   = ~(|val_q) | out_ready;
  assign fast_go    = can_load & ~redir_valid & (cnt_q == '0) & slot_tag[0];
  assign slow_start = can_load & ~redir_valid & (cnt_q == '0) & ~slot_tag[0];
  assign slow_go    = can_load & ~redir_valid & (cnt_q == CNT_LAST);
  assign emit0      = fast_go | slow_go;
  assign emit1      = fast_go & slot_tag[1];
  assign eng_en     = can_load | redir_valid;

  // next state
  always_comb begin
    cnt_d = cnt_q;
    pc_d  = pc_q;
    if (redir_valid) begin
      cnt_d = '0;
      pc_d  = redir_addr;
    end else begin
      if (slow_start)           cnt_d = CNT_W'(1);
      else if (cnt_q == CNT_LAST) cnt_d = '0;
      else if (cnt_q != '0)     cnt_d = cnt_q + CNT_W'(1);
      if (emit1)      pc_d = pc_q + ADDR_W'(slot_end[1]);
      else if (emit0) pc_d = pc_q + ADDR_W'(slot_end[0]);
    end
    val_d = {emit1, emit0};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else if (eng_en) begin
      pc_q  <= pc_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      op0_q <= '0;
      op1_q <= '0;
    end else if (can_load) begin
      val_q <= val_d;
      op0_q <= {slot_addr[0], slot_len[0], slot_opc[0]};
      op1_q <= {slot_addr[1], slot_len[1], slot_opc[1]};
    end
  end

  assign fetch_addr = pc_q;
  assign out_valid  = val_q;
  assign out_op0    = op0_q;
  assign out_op1    = op1_q;

  p_pair_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[1] |-> out_valid[0]);

  p_pair_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[1] |-> (out_op1[OP_W-1 -: ADDR_W] ==
      out_op0[OP_W-1 -: ADDR_W] + ADDR_W'(out_op0[BYTE_W +: LEN_W])));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid && !out_ready) |=>
      ($stable(out_valid) && $stable(out_op0) && $stable(out_op1)));

  p_slow_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slow_go |=> (out_valid == 2'b01));

  p_addr_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    emit0 |=> (out_op0[OP_W-1 -: ADDR_W] == $past(fetch_addr)));
endmodule

// File: tb/sim_dvd_decoder.sv
`timescale 1ns/1ps
module sim_dvd_decoder;
  localparam int AW = 6;
  localparam int WB = 8;
  localparam int NI = 25;
  localparam int MEMSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, tag_clear, redir_valid, out_ready;
  logic [AW-1:0] redir_addr, fetch_addr;
  logic [8*WB-1:0] fetch_bytes;
  logic [1:0] out_valid;
  logic [AW+10:0] out_op0, out_op1;

  logic [7:0] mem [MEMSZ];
  logic [AW-1:0] e_addr [NI];
  logic [2:0]    e_len  [NI];
  logic [7:0]    e_opc  [NI];

  int errors = 0, checks = 0, exp_idx = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dvd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .tag_clear(tag_clear), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .fetch_addr(fetch_addr), .fetch_bytes(fetch_bytes),
    .out_valid(out_valid), .out_op0(out_op0), .out_op1(out_op1), .out_ready(out_ready)
  );

  always_comb begin
    for (int i = 0; i < WB; i++) fetch_bytes[8*i +: 8] = mem[AW'(fetch_addr + AW'(i))];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic take_rec(input logic [AW+10:0] op);
    logic [1:0] kind;
    logic [AW+10:0] ex;
    kind = e_opc[exp_idx][3:2];
    ex = {e_addr[exp_idx], e_len[exp_idx], e_opc[exp_idx]};
    if (kind == 2'd1 || kind == 2'd2) chk(op == ex, "R7 fused record", 32'(op), 32'(ex));
    else chk(op == ex, "R2 record", 32'(op), 32'(ex));
    exp_idx = (exp_idx + 1) % NI;
  endtask

  task automatic tick(input bit rdy, input bit clr, input bit rv, input logic [AW-1:0] ra);
    out_ready = rdy; tag_clear = clr; redir_valid = rv; redir_addr = ra;
    if (rdy && out_valid[0]) take_rec(out_op0);
    if (rdy && out_valid[1]) take_rec(out_op1);
    @(posedge clk); #1;
    tag_clear = 1'b0; redir_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    out_ready = 1'b0;
    @(posedge clk); #1;
    chk(out_valid == 2'b00, "R1 valid in reset", 32'(out_valid), 0);
    chk(fetch_addr == '0, "R1 addr in reset", 32'(fetch_addr), 0);
    rst_n = 1'b1;
    exp_idx = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int a, last, step, nval;
    logic [AW+10:0] h0, h1;
    logic [1:0] hv;
    logic [AW-1:0] ha;
    a = 0;
    for (int k = 0; k < NI; k++) begin
      int len;
      len = (k < NI - 1) ? (k % 4) + 1 : 4;
      e_addr[k] = AW'(a);
      e_len[k]  = 3'(len);
      e_opc[k]  = {4'(k), 2'(k), 2'(len - 1)};
      mem[a] = e_opc[k];
      for (int j = 1; j < len; j++) mem[(a + j) % MEMSZ] = 8'hC0 ^ 8'(a + j);
      a += len;
    end
    tag_clear = 0; redir_valid = 0; redir_addr = '0;
    do_reset();

    // R3: whole loop through the slow path
    last = 0; step = 0; nval = 0;
    while (nval < NI && step < 200) begin
      tick(1, 0, 0, '0);
      step++;
      if (out_valid != 2'b00) begin
        chk(out_valid == 2'b01, "R3 single op", 32'(out_valid), 1);
        chk(step - last == 3, "R3 three-cycle spacing", 32'(step - last), 3);
        last = step; nval++;
      end
    end

    // R4/R5/R10: second loop fast, two per cycle, last pair wraps
    for (int s = 0; s < 13; s++) begin
      tick(1, 0, 0, '0);
      chk(out_valid == 2'b11, s == 0 ? "R4 learned fast path" : "R5 dual issue",
          32'(out_valid), 3);
      if (s == 12)
        chk(out_op1[AW+10:11] == '0, "R10 wrap in pair", 32'(out_op1[AW+10:11]), 0);
    end

    // R8: stall holds outputs
    tick(1, 0, 0, '0);
    h0 = out_op0; h1 = out_op1; hv = out_valid; ha = fetch_addr;
    for (int s = 0; s < 4; s++) begin
      tick(0, 0, 0, '0);
      chk({out_valid, out_op0, out_op1} == {hv, h0, h1}, "R8 hold outputs",
          32'(out_op0), 32'(h0));
      chk(fetch_addr == ha, "R8 hold fetch addr", 32'(fetch_addr), 32'(ha));
    end
    tick(1, 0, 0, '0);
    chk(out_valid == 2'b11, "R8 resume", 32'(out_valid), 3);

    // R9: clear sends code back to the slow path
    tick(1, 1, 0, '0);
    tick(1, 0, 0, '0);
    chk(out_valid == 2'b00, "R9 slow after clear", 32'(out_valid), 0);
    tick(1, 0, 0, '0);
    chk(out_valid == 2'b00, "R9 slow after clear", 32'(out_valid), 0);
    tick(1, 0, 0, '0);
    chk(out_valid == 2'b01, "R9 slow emit after clear", 32'(out_valid), 1);
    tick(1, 0, 0, '0);

    // R6: marked instruction followed by unmarked one
    do_reset();
    for (int s = 1; s <= 9; s++) begin
      tick(1, 0, 0, '0);
      chk(out_valid == ((s % 3 == 0) ? 2'b01 : 2'b00), "R3 slow cadence",
          32'(out_valid), (s % 3 == 0) ? 1 : 0);
    end
    tick(1, 0, 1, e_addr[2]);
    exp_idx = 2;
    chk(out_valid == 2'b00, "R6 redirect bubble", 32'(out_valid), 0);
    tick(1, 0, 0, '0);
    chk(out_valid == 2'b01, "R6 single fast op", 32'(out_valid), 1);
    tick(1, 0, 0, '0);
    chk(out_valid == 2'b00, "R6 fallback slow", 32'(out_valid), 0);
    tick(1, 0, 0, '0);
    chk(out_valid == 2'b00, "R6 fallback slow", 32'(out_valid), 0);
    tick(1, 0, 0, '0);
    chk(out_valid == 2'b01, "R6 fallback emit", 32'(out_valid), 1);
    tick(1, 0, 0, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule